// File: doc/BRIEF.md
# Multi-Mode Test Signal Generator

This block is a free-running source of complex baseband test samples for a data path under bring-up. Each channel produces a stream of 32-bit words, each holding a signed 16-bit in-phase part and a signed 16-bit quadrature part, and hands them out over a valid/ready handshake with a last flag that cuts the stream into packets of a programmable length.

Software sets up each channel through a small write-only register window addressed by a channel index and a byte offset. Three sources can be selected: a fixed complex constant, a sinusoid made by rotating a programmable start vector through a phase that steps by a programmable increment, or pseudo-random noise from a linear feedback shift register scaled by a runtime gain. Packet length and source are sampled only at packet starts, and clearing the enable finishes the open packet before the stream goes quiet.

Top module: `tsg_top`

## Requirements
- R1: After reset no channel presents a valid sample; each channel comes up disabled, constant source (code 0), constant value zero, gain 0x7FFF, phase step zero.
- R2: A write updates only the channel given by `wr_ch`; `wr_addr[4:2]` selects the register (0 enable in bit 0, 1 packet length in bits 15:0, 2 source code in bits 1:0, 3 gain in bits 15:0, 4 constant, 5 phase step in bits 13:0, 6 start vector) and `wr_addr[1:0]` is ignored.
- R3: With source code 0 every output word equals the constant register (I in bits 31:16, Q in bits 15:0); the gain register has no effect on it.
- R4: With source code 2 each sample takes I from bits 31:16 and Q from bits 15:0 of a 32-bit right-shifting Galois LFSR (feedback mask 0x80200003, seed 0x00000001 on channel 0), each part multiplied by the signed Q1.15 gain, rounded by adding 2^14 before an arithmetic shift right by 15, and saturated to 16 bits; the LFSR steps once per noise sample produced.
- R5: With source code 1 sample n equals the start vector (X in bits 31:16, Y in bits 15:0) rotated by n times the phase step, where 8192 step units equal pi radians, and scaled by the rotator gain 1.6468, within 48 LSB; the phase restarts at zero whenever the channel is idle, and the gain register has no effect.
- R6: The last flag is set on every sample whose index within its packet equals the packet length minus one; a packet length of zero behaves as one.
- R7: Changes of packet length or source code take effect only at the next packet start, so a packet never mixes sources or lengths.
- R8: Clearing the enable lets the open packet complete with its last flag, after which no further sample is presented; a disabled idle channel presents nothing.
- R9: While a sample is valid and not accepted, its data and last flag stay unchanged.
- R10: Source code 3 behaves as the constant source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel index of the write |
| wr_addr | input | 5 | Byte offset inside the channel window |
| wr_data | input | 32 | Write data |
| out_ready | input | NUM_CH | Per-channel sink ready |
| out_valid | output | NUM_CH | Per-channel sample valid |
| out_last | output | NUM_CH | Per-channel end of packet |
| out_data | output | NUM_CH*32 | Per-channel sample, channel i in bits 32i+31:32i |

## Verification
A register write is stored on the clock edge that ends its strobe cycle, and a newly enabled channel presents its first sample one edge later; samples then follow one per accepted cycle. Rather than fixing absolute cycle numbers, the bench captures every accepted sample of channel 0 half a cycle after each edge and compares the captured sequence against sequences computed from the requirements, so the checks depend on order and packet position, not on latency. The hold-under-backpressure and reset checks read the ports directly, several cycles after the stimulus has settled.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int SMP_W  = 16;
  localparam int WORD_W = 2 * SMP_W;
  localparam int SPP_W  = 16;
  localparam int PH_W   = 14;
  localparam int ADDR_W = 5;

  localparam logic [1:0] WAVE_FLAT = 2'd0;
  localparam logic [1:0] WAVE_SINE = 2'd1;
  localparam logic [1:0] WAVE_RAND = 2'd2;

  localparam logic [2:0] RI_RUN  = 3'd0;
  localparam logic [2:0] RI_SPP  = 3'd1;
  localparam logic [2:0] RI_WAVE = 3'd2;
  localparam logic [2:0] RI_GAIN = 3'd3;
  localparam logic [2:0] RI_FLAT = 3'd4;
  localparam logic [2:0] RI_STEP = 3'd5;
  localparam logic [2:0] RI_CART = 3'd6;

  typedef struct packed {
    logic              run;
    logic [SPP_W-1:0]  spp;
    logic [1:0]        wave;
    logic [SMP_W-1:0]  gain;
    logic [WORD_W-1:0] flat;
    logic [PH_W-1:0]   step;
    logic [WORD_W-1:0] cart;
  } cfg_t;
endpackage

// File: rtl/tsg_regs.sv
module tsg_regs
  import tsg_pkg::*;
#(
  parameter int              CH_IDX  = 0,
  parameter int              CH_W    = 1,
  parameter logic [SPP_W-1:0] SPP_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output cfg_t              cfg
);
  cfg_t cfg_q, cfg_d;
  logic hit;

  assign hit = wr_en && (wr_ch == CH_W'(CH_IDX));

  always_comb begin
    cfg_d = cfg_q;
    case (wr_addr[4:2])
      RI_RUN:  cfg_d.run  = wr_data[0];
      RI_SPP:  cfg_d.spp  = wr_data[SPP_W-1:0];
      RI_WAVE: cfg_d.wave = wr_data[1:0];
      RI_GAIN: cfg_d.gain = wr_data[SMP_W-1:0];
      RI_FLAT: cfg_d.flat = wr_data;
      RI_STEP: cfg_d.step = wr_data[PH_W-1:0];
      RI_CART: cfg_d.cart = wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.run  <= 1'b0;
      cfg_q.spp  <= SPP_RST;
      cfg_q.wave <= WAVE_FLAT;
      cfg_q.gain <= 16'h7FFF;
      cfg_q.flat <= '0;
      cfg_q.step <= '0;
      cfg_q.cart <= '0;
    end else if (hit) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/tsg_rotator.sv
module tsg_rotator
  import tsg_pkg::*;
#(
  parameter int STAGES = 12,
  parameter int GW     = SMP_W + 2
) (
  input  logic signed [SMP_W-1:0] x_in,
  input  logic signed [SMP_W-1:0] y_in,
  input  logic        [PH_W-1:0]  angle,
  output logic signed [SMP_W-1:0] x_out,
  output logic signed [SMP_W-1:0] y_out
);
  localparam int ZW = PH_W + 1;

  function automatic int atan_unit(input int i);
    case (i)
      0: return 2048;  1: return 1209; 2: return 639; 3: return 324;
      4: return 163;   5: return 81;   6: return 41;  7: return 20;
      8: return 10;    9: return 5;    10: return 3;  11: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic signed [SMP_W-1:0] clip(input logic signed [GW-1:0] v);
    if (v > GW'(32767))       return 16'sh7FFF;
    else if (v < -GW'(32768)) return 16'sh8000;
    else                      return v[SMP_W-1:0];
  endfunction

  logic signed [GW-1:0] xs [STAGES+1];
  logic signed [GW-1:0] ys [STAGES+1];
  logic signed [ZW-1:0] zs [STAGES+1];
  logic                 flip;

  // Angles in the outer half-plane are folded by a half turn first.
  assign flip  = angle[PH_W-1] ^ angle[PH_W-2];
  assign xs[0] = flip ? -GW'(x_in) : GW'(x_in);
  assign ys[0] = flip ? -GW'(y_in) : GW'(y_in);
  assign zs[0] = ZW'($signed({angle[PH_W-1] ^ flip, angle[PH_W-2:0]}));

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic ccw;
    assign ccw       = !zs[i][ZW-1];
    assign xs[i+1]   = ccw ? xs[i] - (ys[i] >>> i) : xs[i] + (ys[i] >>> i);
    assign ys[i+1]   = ccw ? ys[i] + (xs[i] >>> i) : ys[i] - (xs[i] >>> i);
    assign zs[i+1]   = ccw ? zs[i] - ZW'(atan_unit(i)) : zs[i] + ZW'(atan_unit(i));
  end

  assign x_out = clip(xs[STAGES]);
  assign y_out = clip(ys[STAGES]);
endmodule

// File: rtl/tsg_chan.sv
module tsg_chan
  import tsg_pkg::*;
#(
  parameter logic [31:0] SEED       = 32'h0000_0001,
  parameter int          ROT_STAGES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic [WORD_W-1:0] out_data
);
  localparam logic [31:0] FB_MASK = 32'h8020_0003;

  function automatic logic [SMP_W-1:0] scale(input logic signed [SMP_W-1:0] a,
                                              input logic signed [SMP_W-1:0] g);
    logic signed [2*SMP_W-1:0] p;
    logic signed [2*SMP_W:0]   r;
    p = a * g;
    r = ($signed({p[2*SMP_W-1], p}) + (2*SMP_W+1)'(16384)) >>> (SMP_W - 1);
    if (r > (2*SMP_W+1)'(32767)) return 16'h7FFF;
    else                         return r[SMP_W-1:0];
  endfunction

  logic              vld_q, vld_d, last_q, last_d;
  logic [WORD_W-1:0] data_q, data_d, sample;
  logic [SPP_W-1:0]  cnt_q, cnt_d, aspp_q, aspp_d, spp_sel, spp_reg;
  logic [1:0]        amode_q, amode_d, mode_sel;
  logic [31:0]       lfsr_q, lfsr_d;
  logic [PH_W-1:0]   acc_q, acc_d;
  logic              at_start, can_load, load, is_last;
  logic signed [SMP_W-1:0] rot_x, rot_y;

  tsg_rotator #(.STAGES(ROT_STAGES)) u_rot (
    .x_in  (cfg.cart[WORD_W-1:SMP_W]),
    .y_in  (cfg.cart[SMP_W-1:0]),
    .angle (acc_q),
    .x_out (rot_x),
    .y_out (rot_y)
  );

  assign spp_reg  = (cfg.spp == '0) ? SPP_W'(1) : cfg.spp;
  assign at_start = (cnt_q == '0);
  assign mode_sel = at_start ? cfg.wave : amode_q;
  assign spp_sel  = at_start ? spp_reg : aspp_q;
  assign can_load = !vld_q || out_ready;
  assign load     = can_load && (cfg.run || !at_start);
  assign is_last  = (cnt_q == spp_sel - SPP_W'(1));

  always_comb begin
    case (mode_sel)
      WAVE_SINE: sample = {rot_x, rot_y};
      WAVE_RAND: sample = {scale(lfsr_q[31:16], cfg.gain), scale(lfsr_q[15:0], cfg.gain)};
      default:   sample = cfg.flat;
    endcase
  end

  always_comb begin
    vld_d   = vld_q;
    data_d  = data_q;
    last_d  = last_q;
    cnt_d   = cnt_q;
    amode_d = amode_q;
    aspp_d  = aspp_q;
    lfsr_d  = lfsr_q;
    acc_d   = acc_q;
    if (load) begin
      vld_d   = 1'b1;
      data_d  = sample;
      last_d  = is_last;
      cnt_d   = is_last ? '0 : cnt_q + SPP_W'(1);
      amode_d = mode_sel;
      aspp_d  = spp_sel;
      if (mode_sel == WAVE_RAND)
        lfsr_d = lfsr_q[0] ? ((lfsr_q >> 1) ^ FB_MASK) : (lfsr_q >> 1);
      if (mode_sel == WAVE_SINE)
        acc_d = acc_q + cfg.step;
    end else begin
      if (can_load) vld_d = 1'b0;
      if (at_start && !cfg.run) acc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
      cnt_q   <= '0;
      amode_q <= WAVE_FLAT;
      aspp_q  <= SPP_W'(1);
      lfsr_q  <= SEED;
      acc_q   <= '0;
    end else begin
      vld_q   <= vld_d;
      lfsr_q  <= lfsr_d;
      acc_q   <= acc_d;
      if (load) begin
        data_q  <= data_d;
        last_q  <= last_d;
        cnt_q   <= cnt_d;
        amode_q <= amode_d;
        aspp_q  <= aspp_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_last  = last_q;
  assign out_data  = data_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run && at_start && out_ready) |=> !out_valid); // R8
  AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> at_start); // R6
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 32'h0); // R4
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run && at_start && !load) |=> (acc_q == '0)); // R5
endmodule

// File: rtl/tsg_top.sv
module tsg_top
  import tsg_pkg::*;
#(
  parameter int              NUM_CH    = 2,
  parameter logic [SPP_W-1:0] SPP_RST   = 16,
  parameter logic [31:0]     LFSR_SEED = 32'h0000_0001,
  parameter int              ROT_STAGES = 12,
  localparam int             CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]        out_ready,
  output logic [NUM_CH-1:0]        out_valid,
  output logic [NUM_CH-1:0]        out_last,
  output logic [NUM_CH*WORD_W-1:0] out_data
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cfg_t cfg;

    tsg_regs #(.CH_IDX(c), .CH_W(CH_W), .SPP_RST(SPP_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_sn),
      .wr_en   (wr_en),
      .wr_ch   (wr_ch),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg     (cfg)
    );

    tsg_chan #(.SEED(LFSR_SEED + 32'(c)), .ROT_STAGES(ROT_STAGES)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sn),
      .cfg       (cfg),
      .out_ready (out_ready[c]),
      .out_valid (out_valid[c]),
      .out_last  (out_last[c]),
      .out_data  (out_data[c*WORD_W +: WORD_W])
    );
  end
endmodule

// File: tb/tb_tsg_top.sv
`timescale 1ns/1ps
module tb_tsg_top;
  localparam int NCH = 2;
  localparam real KROT = 1.6467602;
  localparam real PI = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_ch = '0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NCH-1:0]    out_ready = '1;
  logic [NCH-1:0]    out_valid, out_last;
  logic [NCH*32-1:0] out_data;

  tsg_top #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_ready(out_ready), .out_valid(out_valid),
    .out_last(out_last), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] cap_d [1024];
  logic        cap_l [1024];
  int          cap_n = 0;
  logic [31:0] m_lfsr = 32'h0000_0001;

  always @(negedge clk)
    if (rst_n && out_valid[0] && out_ready[0] && cap_n < 1024) begin
      cap_d[cap_n] = out_data[31:0];
      cap_l[cap_n] = out_last[0];
      cap_n++;
    end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int addr, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_ch = ch[0:0]; wr_addr = addr[4:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] nscale(input logic [15:0] a, input logic [15:0] g);
    longint p, r;
    p = longint'($signed(a)) * longint'($signed(g));
    r = (p + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  // Constant-source vectors: constant, packet length, gain, run cycles
  localparam logic [31:0] TV_FLAT [4] = '{32'h4000_C000, 32'h7FFF_8000, 32'h0001_FFFF, 32'h1234_5678};
  localparam int          TV_SPP  [4] = '{4, 1, 0, 3};
  localparam logic [15:0] TV_GAIN [4] = '{16'h2000, 16'h0000, 16'h4000, 16'h7FFF};
  localparam int          TV_RUN  [4] = '{10, 5, 3, 7};

  task automatic run_flat(input logic [31:0] flat, input int spp, input logic [15:0] gain,
                          input int run, input logic [1:0] code, input string req);
    int eff, bad_d, bad_l;
    eff = (spp == 0) ? 1 : spp;
    cap_n = 0;
    wr(0, 5'h08, {30'd0, code});
    wr(0, 5'h10, flat);
    wr(0, 5'h04, spp);
    wr(0, 5'h0C, {16'd0, gain});
    wr(0, 5'h00, 32'd1);
    cyc(run);
    wr(0, 5'h00, 32'd0);
    cyc(20);
    bad_d = 0; bad_l = 0;
    for (int i = 0; i < cap_n; i++) begin
      if (cap_d[i] !== flat) bad_d++;
      if (cap_l[i] !== ((i % eff) == eff - 1)) bad_l++;
    end
    chk(cap_n > 0 && bad_d == 0, req, bad_d, 0);
    chk(bad_l == 0, "R6 last position", bad_l, 0);
    chk(cap_n % eff == 0, "R8 packet completes after disable", cap_n % eff, 0);
  endtask

  task automatic run_noise(input logic [15:0] gain);
    int bad;
    logic [31:0] exp_w;
    cap_n = 0;
    wr(0, 5'h08, 32'd2);
    wr(0, 5'h04, 32'd8);
    wr(0, 5'h0C, {16'd0, gain});
    wr(0, 5'h00, 32'd1);
    cyc(12);
    wr(0, 5'h00, 32'd0);
    cyc(20);
    bad = 0;
    for (int i = 0; i < cap_n; i++) begin
      exp_w = {nscale(m_lfsr[31:16], gain), nscale(m_lfsr[15:0], gain)};
      if (cap_d[i] !== exp_w) begin
        if (bad == 0) $display("FAIL R4 noise sample %0d actual=%h expected=%h", i, cap_d[i], exp_w);
        bad++;
      end
      m_lfsr = lfsr_step(m_lfsr);
    end
    checks++;
    if (bad != 0 || cap_n == 0) errors++;
  endtask

  task automatic run_sine(input int x0, input int y0, input int step, input int spp);
    int bad, xi, yi;
    real th, ex, ey;
    cap_n = 0;
    wr(0, 5'h08, 32'd1);
    wr(0, 5'h18, {x0[15:0], y0[15:0]});
    wr(0, 5'h14, step);
    wr(0, 5'h04, spp);
    wr(0, 5'h0C, 32'h0000_8000);
    wr(0, 5'h00, 32'd1);
    cyc(10);
    wr(0, 5'h00, 32'd0);
    cyc(20);
    bad = 0;
    for (int n = 0; n < 8; n++) begin
      th = real'(n * step) * PI / 8192.0;
      ex = KROT * (real'(x0) * $cos(th) - real'(y0) * $sin(th));
      ey = KROT * (real'(x0) * $sin(th) + real'(y0) * $cos(th));
      xi = int'($signed(cap_d[n][31:16]));
      yi = int'($signed(cap_d[n][15:0]));
      if ((real'(xi) - ex > 48.0) || (ex - real'(xi) > 48.0) ||
          (real'(yi) - ey > 48.0) || (ey - real'(yi) > 48.0)) begin
        if (bad == 0) $display("FAIL R5 sine sample %0d actual=(%0d,%0d) expected=(%0d,%0d)",
                               n, xi, yi, int'(ex), int'(ey));
        bad++;
      end
    end
    checks++;
    if (bad != 0 || cap_n < 8) errors++;
  endtask

  initial begin
    logic [31:0] held_d;
    logic        held_l;
    logic [31:0] e6, e7;

    cyc(4);
    chk(out_valid === '0, "R1 valid low in reset", out_valid, 0);
    rst_n = 1'b1;
    cyc(6);
    chk(out_valid === '0, "R1 disabled after reset", out_valid, 0);

    // Constant source vectors
    for (int t = 0; t < 4; t++)
      run_flat(TV_FLAT[t], TV_SPP[t], TV_GAIN[t], TV_RUN[t], 2'd0, "R3 constant word");

    // Noise source, two gains (R4)
    run_noise(16'h4000);
    run_noise(16'h8000);

    // Sine source (R5), quarter-turn and finer step
    run_sine(10000, 0, 4096, 4);
    run_sine(6000, -8000, 1365, 5);

    // Mode and length change inside a packet (R7)
    cap_n = 0;
    wr(0, 5'h08, 32'd0);
    wr(0, 5'h10, 32'h0ABC_0DEF);
    wr(0, 5'h04, 32'd6);
    wr(0, 5'h0C, 32'h0000_4000);
    wr(0, 5'h00, 32'd1);
    cyc(1);
    wr(0, 5'h08, 32'd2);
    wr(0, 5'h04, 32'd2);
    cyc(6);
    wr(0, 5'h00, 32'd0);
    cyc(20);
    chk(cap_d[0] === 32'h0ABC_0DEF && cap_d[5] === 32'h0ABC_0DEF && cap_l[5] === 1'b1,
        "R7 first packet stays constant", cap_d[5], 32'h0ABC_0DEF);
    e6 = {nscale(m_lfsr[31:16], 16'h4000), nscale(m_lfsr[15:0], 16'h4000)};
    e7 = lfsr_step(m_lfsr);
    e7 = {nscale(e7[31:16], 16'h4000), nscale(e7[15:0], 16'h4000)};
    chk(cap_d[6] === e6 && cap_l[6] === 1'b0, "R7 noise from next packet", cap_d[6], e6);
    chk(cap_d[7] === e7 && cap_l[7] === 1'b1, "R7 new length at boundary", cap_d[7], e7);

    // Backpressure hold (R9)
    cap_n = 0;
    wr(0, 5'h08, 32'd0);
    wr(0, 5'h10, 32'h1111_2222);
    wr(0, 5'h04, 32'd3);
    wr(0, 5'h00, 32'd1);
    cyc(2);
    out_ready[0] = 1'b0;
    @(negedge clk);
    held_d = out_data[31:0];
    held_l = out_last[0];
    cyc(4);
    @(negedge clk);
    chk(out_valid[0] && out_data[31:0] === held_d && out_last[0] === held_l,
        "R9 held under backpressure", out_data[31:0], held_d);
    @(posedge clk); #1;
    out_ready[0] = 1'b1;
    wr(0, 5'h00, 32'd0);
    cyc(20);
    chk(cap_n % 3 == 0, "R8 packet completes after stall", cap_n % 3, 0);
    chk(out_valid[0] === 1'b0, "R8 quiet after stop", out_valid[0], 0);

    // Reserved code 3 (R10)
    run_flat(32'h0F0F_F0F0, 2, 16'h1000, 6, 2'd3, "R10 code 3 acts as constant");

    // Channel isolation and ignored low address bits (R2)
    wr(1, 5'h12, 32'h5555_AAAA);
    wr(1, 5'h04, 32'd1);
    wr(1, 5'h00, 32'd1);
    cyc(3);
    @(negedge clk);
    chk(out_valid[1] && out_data[63:32] === 32'h5555_AAAA, "R2 channel 1 own constant",
        out_data[63:32], 32'h5555_AAAA);
    chk(out_valid[0] === 1'b0, "R2 channel 0 untouched", out_valid[0], 0);
    wr(1, 5'h00, 32'd0);
    cyc(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule